// File: doc/BRIEF.md
# Multiplex-Aware Display Bitmap Loader

This block fills an 8-row by 44-column display bitmap from a stream of 8-bit bytes that an upstream bus decoder hands over. Software first sets a column pointer. Each byte that follows is cut into column slices. The slice height depends on the selected multiplex ratio: 4 rows in quarter mode, 6 rows in sixth mode and 8 rows in eighth mode. The slices go into the bitmap, and the pointer moves on by the number of columns that the byte completed. Row n of the bitmap feeds backplane n, and column m feeds segment m.

In sixth mode the bits pack with no gaps, so a column can take bits from two bytes in a row. A residual counter remembers how far down the current column has been filled. The pointer does not wrap at the right-hand edge. It stops at the last column, and everything after that point is dropped until the pointer is loaded again. An aborted transfer marks the pointer as stale, and all data is refused until a new pointer load arrives. A combinational read port gives the backplane scanner any one full row.

Top module: `dispram_loader`

## Requirements
- R1: After reset every bitmap bit reads 0, the pointer is column 0 with no residual bits, and the first byte is accepted.
- R2: A pointer load sets the column to ptr_value, clamped to 43 when it is larger. It clears the residual count, the saturation state and the stale state. The next byte starts at row 0 of that column.
- R3: With mux_mode 2'b10 (2'b11 behaves the same), byte bit 7 goes to row 0, down to bit 0 in row 7, all in the current column. The pointer then advances by one.
- R4: With mux_mode 2'b00, byte bits 7..4 go to rows 0..3 of column p and bits 3..0 go to rows 0..3 of column p+1. The pointer then advances by two.
- R5: With mux_mode 2'b01, byte bit 7-k (k=0..7) goes to column p+(r+k)/6, row (r+k)%6, where r is the residual count (0..5). Afterwards r becomes (r+8)%6 and p grows by (r+8)/6.
- R6: Rows 4..7 in mode 2'b00 and rows 6..7 in mode 2'b01 are never written. They keep their earlier contents.
- R7: Bits that would land beyond column 43 are dropped. When a byte's advance would move past column 43, the pointer saturates at 43 and all later bytes are dropped until the next pointer load.
- R8: A xfer_abort pulse makes the pointer stale. Bytes are dropped while the pointer is stale, and only a pointer load clears it.
- R9: In one cycle, xfer_abort has priority over ptr_load, and ptr_load has priority over byte_valid. A byte strobed in the same cycle as a load or an abort is dropped.
- R10: rd_bits bit m equals the bitmap bit at row rd_row, column m. It changes as soon as rd_row changes, and it shows a write from the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_load | input | 1 | Pointer load strobe |
| ptr_value | input | 6 | Column value for a pointer load |
| byte_valid | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte, MSB first |
| xfer_abort | input | 1 | Transfer ended early |
| mux_mode | input | 2 | 00 quarter, 01 sixth, 10/11 eighth |
| rd_row | input | 3 | Row selected for reading |
| rd_bits | output | 44 | Selected row, bit m = column m |

## Verification
Eighth-mode bytes with asymmetric patterns such as A5 and 3C show whether the bit order runs MSB-first down a column and whether each byte goes to its own column. Quarter-mode and sixth-mode bytes are written over columns that are already all ones, which shows that the unused low rows stay untouched. A run of three sixth-mode bytes covers all three residual values, including a byte that finishes two columns. Loads above 43 and bytes written near the edge in sixth mode check clamping, dropped leftover bits and saturation. Aborts and strobes in the same cycle check that stale data is refused and that the stated priority holds.

// File: rtl/dispram_pkg.sv
package dispram_pkg;

    localparam int BYTE_W = 8;
    localparam int RES_W  = 3;
    localparam int OFF_W  = 4;

    typedef enum logic [1:0] {
        MUX_QUAD    = 2'b00,
        MUX_SEXT    = 2'b01,
        MUX_OCT     = 2'b10,
        MUX_OCT_ALT = 2'b11
    } mux_mode_e;

    typedef struct packed {
        logic [OFF_W-1:0] off;
        logic [2:0]       row;
    } slot_t;

    // Map a linear bit index (residual + bit number) to column offset and row.
    function automatic slot_t locate(logic [OFF_W-1:0] idx, mux_mode_e m);
        slot_t s;
        case (m)
            MUX_QUAD: begin
                s.off = {2'b00, idx[3:2]};
                s.row = {1'b0, idx[1:0]};
            end
            MUX_SEXT: begin
                if (idx < 4'd6) begin
                    s.off = 4'd0;
                    s.row = idx[2:0];
                end else if (idx < 4'd12) begin
                    s.off = 4'd1;
                    s.row = 3'(idx - 4'd6);
                end else begin
                    s.off = 4'd2;
                    s.row = 3'(idx - 4'd12);
                end
            end
            default: begin
                s.off = {3'b000, idx[3]};
                s.row = idx[2:0];
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/slice_planner.sv
module slice_planner
    import dispram_pkg::*;
#(
    parameter  int NUM_ROWS = 8,
    parameter  int NUM_COLS = 44,
    localparam int PTR_W    = $clog2(NUM_COLS),
    localparam int CW       = PTR_W + 1
) (
    input  logic                               enable,
    input  logic [PTR_W-1:0]                   ptr,
    input  logic [RES_W-1:0]                   resid,
    input  mux_mode_e                          mode,
    input  logic [BYTE_W-1:0]                  data,
    output logic [NUM_ROWS-1:0][NUM_COLS-1:0]  wr_en,
    output logic [NUM_ROWS-1:0][NUM_COLS-1:0]  wr_val,
    output logic [OFF_W-1:0]                   advance,
    output logic [RES_W-1:0]                   resid_next
);

    logic [BYTE_W-1:0]  bit_ok;
    logic [2:0]         bit_row [BYTE_W];
    logic [PTR_W-1:0]   bit_col [BYTE_W];

    generate
        for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
            slot_t          slot_k;
            logic [CW-1:0]  col_k;
            assign slot_k     = locate(OFF_W'(resid) + OFF_W'(k), mode);
            assign col_k      = {1'b0, ptr} + CW'(slot_k.off);
            assign bit_ok[k]  = col_k < CW'(NUM_COLS);
            assign bit_row[k] = slot_k.row;
            assign bit_col[k] = col_k[PTR_W-1:0];
        end
    endgenerate

    slot_t tail;
    assign tail       = locate(OFF_W'(resid) + OFF_W'(BYTE_W), mode);
    assign advance    = tail.off;
    assign resid_next = tail.row;

    always_comb begin
        wr_en  = '0;
        wr_val = '0;
        for (int k = 0; k < BYTE_W; k++) begin
            if (enable && bit_ok[k]) begin
                wr_en[bit_row[k]][bit_col[k]]  = 1'b1;
                wr_val[bit_row[k]][bit_col[k]] = data[BYTE_W-1-k];
            end
        end
    end

endmodule

// File: rtl/pointer_ctrl.sv
module pointer_ctrl
    import dispram_pkg::*;
#(
    parameter  int NUM_COLS = 44,
    localparam int PTR_W    = $clog2(NUM_COLS),
    localparam int CW       = PTR_W + 1,
    localparam logic [PTR_W-1:0] LAST_COL = PTR_W'(NUM_COLS - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_load,
    input  logic [PTR_W-1:0]  ptr_value,
    input  logic              xfer_abort,
    input  logic              byte_valid,
    input  logic [OFF_W-1:0]  advance,
    input  logic [RES_W-1:0]  resid_next,
    output logic [PTR_W-1:0]  ptr,
    output logic [RES_W-1:0]  resid,
    output logic              saturated,
    output logic              stale,
    output logic              accept
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [RES_W-1:0] resid;
        logic             sat;
        logic             stale;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [CW-1:0] sum;

    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        sum    = {1'b0, st_q.ptr} + CW'(advance);
        if (xfer_abort) begin
            st_d.stale = 1'b1;
        end else if (ptr_load) begin
            st_d.ptr   = (ptr_value > LAST_COL) ? LAST_COL : ptr_value;
            st_d.resid = '0;
            st_d.sat   = 1'b0;
            st_d.stale = 1'b0;
        end else if (byte_valid && !st_q.stale && !st_q.sat) begin
            accept = 1'b1;
            if (sum >= CW'(NUM_COLS)) begin
                st_d.ptr   = LAST_COL;
                st_d.resid = '0;
                st_d.sat   = 1'b1;
            end else begin
                st_d.ptr   = sum[PTR_W-1:0];
                st_d.resid = resid_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr       = st_q.ptr;
    assign resid     = st_q.resid;
    assign saturated = st_q.sat;
    assign stale     = st_q.stale;

endmodule

// File: rtl/bitmap_store.sv
module bitmap_store #(
    parameter  int NUM_ROWS = 8,
    parameter  int NUM_COLS = 44,
    localparam int ROW_W    = $clog2(NUM_ROWS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_ROWS-1:0][NUM_COLS-1:0]  wr_en,
    input  logic [NUM_ROWS-1:0][NUM_COLS-1:0]  wr_val,
    input  logic [ROW_W-1:0]                   rd_row,
    output logic [NUM_COLS-1:0]                rd_bits
);

    logic [NUM_ROWS-1:0][NUM_COLS-1:0] map_d, map_q;

    always_comb begin
        for (int r = 0; r < NUM_ROWS; r++) begin
            map_d[r] = (map_q[r] & ~wr_en[r]) | (wr_val[r] & wr_en[r]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= map_d;
    end

    assign rd_bits = map_q[rd_row];

endmodule

// File: rtl/dispram_loader.sv
module dispram_loader
    import dispram_pkg::*;
#(
    parameter  int NUM_ROWS = 8,
    parameter  int NUM_COLS = 44,
    localparam int PTR_W    = $clog2(NUM_COLS),
    localparam int ROW_W    = $clog2(NUM_ROWS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ptr_load,
    input  logic [PTR_W-1:0]     ptr_value,
    input  logic                 byte_valid,
    input  logic [BYTE_W-1:0]    byte_data,
    input  logic                 xfer_abort,
    input  logic [1:0]           mux_mode,
    input  logic [ROW_W-1:0]     rd_row,
    output logic [NUM_COLS-1:0]  rd_bits
);

    logic [PTR_W-1:0]  ptr_cur;
    logic [RES_W-1:0]  resid_cur;
    logic [RES_W-1:0]  resid_nxt;
    logic [OFF_W-1:0]  col_advance;
    logic              sat_cur;
    logic              stale_cur;
    logic              byte_accept;
    mux_mode_e         mode;

    logic [NUM_ROWS-1:0][NUM_COLS-1:0] wr_en, wr_val;

    assign mode = mux_mode_e'(mux_mode);

    pointer_ctrl #(.NUM_COLS(NUM_COLS)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr_load   (ptr_load),
        .ptr_value  (ptr_value),
        .xfer_abort (xfer_abort),
        .byte_valid (byte_valid),
        .advance    (col_advance),
        .resid_next (resid_nxt),
        .ptr        (ptr_cur),
        .resid      (resid_cur),
        .saturated  (sat_cur),
        .stale      (stale_cur),
        .accept     (byte_accept)
    );

    slice_planner #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_plan (
        .enable     (byte_accept),
        .ptr        (ptr_cur),
        .resid      (resid_cur),
        .mode       (mode),
        .data       (byte_data),
        .wr_en      (wr_en),
        .wr_val     (wr_val),
        .advance    (col_advance),
        .resid_next (resid_nxt)
    );

    bitmap_store #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_val  (wr_val),
        .rd_row  (rd_row),
        .rd_bits (rd_bits)
    );

endmodule

// File: rtl/dispram_loader_checker.sv
module dispram_loader_checker #(
    parameter int NUM_COLS = 44,
    parameter int PTR_W    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ptr_load,
    input logic [PTR_W-1:0] ptr_value,
    input logic             byte_valid,
    input logic             xfer_abort,
    input logic [1:0]       mux_mode,
    input logic [PTR_W-1:0] ptr_q,
    input logic [2:0]       resid_q,
    input logic             sat_q,
    input logic             stale_q
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_COLS - 1);

    logic takes_byte;
    assign takes_byte = byte_valid && !xfer_abort && !ptr_load && !stale_q && !sat_q;

    p_ptr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= LAST);

    p_resid_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        resid_q < 3'd6);

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_load && !xfer_abort) |=>
            (ptr_q == (($past(ptr_value) > LAST) ? LAST : $past(ptr_value)))
            && resid_q == 3'd0 && !sat_q && !stale_q);

    p_step_oct_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (takes_byte && mux_mode[1] && ptr_q < LAST) |=> ptr_q == $past(ptr_q) + 1'b1);

    p_step_quad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (takes_byte && mux_mode == 2'b00 && resid_q == 3'd0 && ptr_q < LAST - 1'b1)
            |=> ptr_q == $past(ptr_q) + 2'd2 && resid_q == 3'd0);

    p_sext_resid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (takes_byte && mux_mode == 2'b01 && ptr_q < LAST - 1'b1)
            |=> resid_q == (($past(resid_q) + 3'd2) % 3'd6));

    p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_q && !ptr_load) |=> sat_q && ptr_q == LAST);

    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_abort |=> stale_q);

    p_stale_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stale_q && (!ptr_load || xfer_abort)) |=> stale_q && $stable(ptr_q));

    p_abort_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_abort && ptr_load && !stale_q) |=> stale_q && $stable(ptr_q));

endmodule

bind dispram_loader dispram_loader_checker #(.NUM_COLS(NUM_COLS), .PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptr_load   (ptr_load),
    .ptr_value  (ptr_value),
    .byte_valid (byte_valid),
    .xfer_abort (xfer_abort),
    .mux_mode   (mux_mode),
    .ptr_q      (ptr_cur),
    .resid_q    (resid_cur),
    .sat_q      (sat_cur),
    .stale_q    (stale_cur)
);

// File: tb/dispram_loader_test.sv
`timescale 1ns/1ps
module dispram_loader_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr_load = 1'b0;
    logic [5:0]  ptr_value = '0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        xfer_abort = 1'b0;
    logic [1:0]  mux_mode = 2'b10;
    logic [2:0]  rd_row = '0;
    logic [43:0] rd_bits;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [43:0] exp_map [8];
    int  m_ptr, m_res;
    bit  m_sat, m_stale;

    always #2 clk = ~clk;

    dispram_loader uut (
        .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_value(ptr_value),
        .byte_valid(byte_valid), .byte_data(byte_data), .xfer_abort(xfer_abort),
        .mux_mode(mux_mode), .rd_row(rd_row), .rd_bits(rd_bits)
    );

    task automatic check_map(string req);
        for (int r = 0; r < 8; r++) begin
            rd_row = 3'(r);
            #0.2;
            n_cmp++;
            if (rd_bits !== exp_map[r]) begin
                n_bad++;
                $display("FAIL %s row %0d: actual %h expected %h", req, r, rd_bits, exp_map[r]);
            end
        end
    endtask

    task automatic model_byte(logic [7:0] d);
        int h, idx, c, adv;
        if (m_stale || m_sat) return;
        h = (mux_mode == 2'b00) ? 4 : (mux_mode == 2'b01) ? 6 : 8;
        for (int k = 0; k < 8; k++) begin
            idx = m_res + k;
            c = m_ptr + idx / h;
            if (c < 44) exp_map[idx % h][c] = d[7-k];
        end
        adv = (m_res + 8) / h;
        if (m_ptr + adv >= 44) begin
            m_ptr = 43; m_sat = 1; m_res = 0;
        end else begin
            m_ptr = m_ptr + adv; m_res = (m_res + 8) % h;
        end
    endtask

    task automatic send_load(int v);
        @(negedge clk); ptr_load = 1'b1; ptr_value = 6'(v);
        @(negedge clk); ptr_load = 1'b0;
        m_ptr = (v > 43) ? 43 : v; m_res = 0; m_sat = 0; m_stale = 0;
    endtask

    task automatic send_byte(logic [7:0] d);
        @(negedge clk); byte_valid = 1'b1; byte_data = d;
        @(negedge clk); byte_valid = 1'b0;
        model_byte(d);
    endtask

    task automatic send_abort();
        @(negedge clk); xfer_abort = 1'b1;
        @(negedge clk); xfer_abort = 1'b0;
        m_stale = 1;
    endtask

    task automatic t_reset();
        for (int r = 0; r < 8; r++) exp_map[r] = '0;
        m_ptr = 0; m_res = 0; m_sat = 0; m_stale = 0;
        check_map("R1 reset");
        mux_mode = 2'b10;
        send_byte(8'h81);
        check_map("R1 first byte at column 0");
    endtask

    task automatic t_oct();
        mux_mode = 2'b10;
        send_load(5);
        send_byte(8'hA5);
        send_byte(8'h3C);
        check_map("R3 eighth mode");
        mux_mode = 2'b11;
        send_byte(8'h69);
        check_map("R3 mode 11 as eighth");
        rd_row = 3'd0; #0.2;
        n_cmp++;
        if (rd_bits[5] !== 1'b1 || rd_bits[6] !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 row0 cols5..6: actual %b%b expected 10", rd_bits[5], rd_bits[6]);
        end
    endtask

    task automatic t_quad();
        mux_mode = 2'b10;
        send_load(10);
        send_byte(8'hFF);
        send_byte(8'hFF);
        mux_mode = 2'b00;
        send_load(10);
        send_byte(8'h90);
        check_map("R4 quarter mode split, R6 rows 4..7 kept");
        send_byte(8'h5A);
        check_map("R4 second byte advance by two");
    endtask

    task automatic t_sext();
        mux_mode = 2'b10;
        send_load(20);
        for (int i = 0; i < 5; i++) send_byte(8'hFF);
        mux_mode = 2'b01;
        send_load(20);
        send_byte(8'h00);
        check_map("R5 sixth mode r=0");
        send_byte(8'h24);
        check_map("R5 sixth mode r=2");
        send_byte(8'hC3);
        check_map("R5 sixth mode r=4, R6 rows 6..7 kept");
        send_byte(8'h0F);
        check_map("R5 sixth mode after two-column byte");
    endtask

    task automatic t_edge();
        mux_mode = 2'b10;
        send_load(60);
        send_byte(8'h81);
        send_byte(8'h7E);
        check_map("R2 clamp to 43, R7 saturation drop");
        mux_mode = 2'b01;
        send_load(42);
        send_byte(8'hF0);
        send_byte(8'hAA);
        send_byte(8'h55);
        check_map("R7 sixth mode edge and saturation");
        mux_mode = 2'b00;
        send_load(43);
        send_byte(8'hC3);
        send_byte(8'hFF);
        check_map("R7 quarter mode low nibble dropped");
    endtask

    task automatic t_abort();
        mux_mode = 2'b10;
        send_load(0);
        send_byte(8'h11);
        send_abort();
        send_byte(8'hEE);
        check_map("R8 byte dropped while stale");
        send_load(30);
        send_byte(8'hE7);
        check_map("R8 reload resumes writing");
    endtask

    task automatic t_prio();
        mux_mode = 2'b10;
        @(negedge clk); ptr_load = 1'b1; ptr_value = 6'd7; byte_valid = 1'b1; byte_data = 8'hFF;
        @(negedge clk); ptr_load = 1'b0; byte_valid = 1'b0;
        m_ptr = 7; m_res = 0; m_sat = 0; m_stale = 0;
        check_map("R9 byte with load dropped");
        send_byte(8'h0F);
        check_map("R9 load applied");
        @(negedge clk); xfer_abort = 1'b1; ptr_load = 1'b1; ptr_value = 6'd3;
        @(negedge clk); xfer_abort = 1'b0; ptr_load = 1'b0;
        m_stale = 1;
        send_byte(8'hFF);
        check_map("R9 abort beats load");
        @(negedge clk); xfer_abort = 1'b1; byte_valid = 1'b1; byte_data = 8'hFF;
        @(negedge clk); xfer_abort = 1'b0; byte_valid = 1'b0;
        send_load(3);
        send_byte(8'hC0);
        check_map("R9 byte with abort dropped, R2 reload");
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oct();
        t_quad();
        t_sext();
        t_edge();
        t_abort();
        t_prio();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule